// File: doc/BRIEF.md
# Two-Input Serial Sequence Machine with Registered Output

This block is a small synchronous state machine that reads a pair of serial input bits, x1 and x2, on every rising clock edge and produces one output bit, z. Its behaviour is defined by a two-state transition and output table with states A and B. The output is a function of the present state and the current input pair. By default the block realises that behaviour as a registered machine. The output bit is stored beside the state bit, so z depends only on the register contents and follows the input pair that caused it by exactly one clock.

A build-time parameter, `MEALY_MODE`, selects the other variant. With it set, z is formed combinationally from the present state and the live inputs, and the output register bit is not used. The state transitions are the same in both variants. The block has no handshake. One input pair is consumed on every clock edge, and reset is synchronous and active-high.

Top module: `mm_top`

## Requirements
- R1: A clock edge with `rst` high puts the machine in state A. In registered mode z is 0 from that edge until the first edge after `rst` falls. In combinational mode z then follows the state-A rule of R4.
- R2: In state A, the pair x1=1, x2=1 moves the machine to state B. Every other pair keeps it in A.
- R3: In state B, the pair x1=0, x2=0 moves the machine to state A. Every other pair keeps it in B.
- R4: The table output in state A is 1 when x1 and x2 differ and 0 when they are equal.
- R5: The table output in state B is 1 when x1 and x2 are equal and 0 when they differ.
- R6: In registered mode (`MEALY_MODE`=0), z after clock edge n equals the table output formed from the state and the input pair present at edge n.
- R7: In registered mode, changes of x1 and x2 between clock edges do not change z. Only the values present at the rising edge reach the state.
- R8: In combinational mode (`MEALY_MODE`=1), z equals the table output of the present state and the current x1, x2, with no clock between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to state A with stored output 0 |
| x1 | input | 1 | First serial input bit |
| x2 | input | 1 | Second serial input bit |
| z | output | 1 | Machine output, registered or combinational depending on `MEALY_MODE` |

## Verification
The bench builds the block twice, once with `MEALY_MODE`=0 and once with `MEALY_MODE`=1, and drives both from the same input stream. Through the combinational instance the present state can be read in the same cycle, using a probe pair of 00 that gives 0 in A and 1 in B. Through the registered instance the bench sees the same table value one edge later. With both instances on one stream, the one-cycle lag and the complete eight-entry table can be checked against a single reference model. Directed walks, a mid-cycle input glitch, a reset taken from state B, and a long pseudo-random stream are all checked this way.

// File: rtl/mm_pkg.sv
package mm_pkg;
  // Registered-form states: {table state bit, output carried on arrival}
  typedef enum logic [1:0] {
    MM_A0 = 2'b00,
    MM_A1 = 2'b01,
    MM_B0 = 2'b10,
    MM_B1 = 2'b11
  } mm_state_e;

  localparam int unsigned MM_ST_W   = 2;
  localparam int unsigned MM_PAIR_W = 2;
  localparam logic [MM_ST_W-1:0] MM_RESET_ST = MM_A0;
endpackage

// File: rtl/mm_next_logic.sv
module mm_next_logic
  import mm_pkg::*;
#(
  parameter int unsigned PAIR_W = MM_PAIR_W
) (
  input  logic [PAIR_W-1:0] pair_in,
  input  logic              cur_b,
  output logic              nxt_b,
  output logic              tbl_z
);
  // pair_in = {x1, x2}
  always_comb begin
    nxt_b = cur_b;
    tbl_z = 1'b0;
    if (!cur_b) begin
      unique case (pair_in)
        2'b00:   begin nxt_b = 1'b0; tbl_z = 1'b0; end
        2'b01:   begin nxt_b = 1'b0; tbl_z = 1'b1; end
        2'b11:   begin nxt_b = 1'b1; tbl_z = 1'b0; end
        default: begin nxt_b = 1'b0; tbl_z = 1'b1; end
      endcase
    end else begin
      unique case (pair_in)
        2'b00:   begin nxt_b = 1'b0; tbl_z = 1'b1; end
        2'b01:   begin nxt_b = 1'b1; tbl_z = 1'b0; end
        2'b11:   begin nxt_b = 1'b1; tbl_z = 1'b1; end
        default: begin nxt_b = 1'b1; tbl_z = 1'b0; end
      endcase
    end
  end
endmodule

// File: rtl/mm_state_reg.sv
module mm_state_reg #(
  parameter int unsigned          W         = 2,
  parameter logic [W-1:0]         RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RESET_VAL;
    else     q <= d;
  end
endmodule

// File: rtl/mm_out_sel.sv
module mm_out_sel #(
  parameter bit MEALY_MODE = 1'b0
) (
  input  logic tbl_z,
  input  logic stored_z,
  output logic z
);
  generate
    if (MEALY_MODE) begin : g_comb
      assign z = tbl_z;
    end else begin : g_reg
      assign z = stored_z;
    end
  endgenerate
endmodule

// File: rtl/mm_top.sv
module mm_top
  import mm_pkg::*;
#(
  parameter bit MEALY_MODE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic x1,
  input  logic x2,
  output logic z
);
  localparam int unsigned ST_W   = MM_ST_W;
  localparam int unsigned PAIR_W = MM_PAIR_W;

  logic [ST_W-1:0]   st_q;
  logic [ST_W-1:0]   st_d;
  logic [PAIR_W-1:0] pair;
  logic              nxt_b;
  logic              tbl_z;

  assign pair = {x1, x2};

  mm_next_logic #(.PAIR_W(PAIR_W)) u_next (
    .pair_in (pair),
    .cur_b   (st_q[1]),
    .nxt_b   (nxt_b),
    .tbl_z   (tbl_z)
  );

  assign st_d = {nxt_b, tbl_z};

  mm_state_reg #(.W(ST_W), .RESET_VAL(MM_RESET_ST)) u_reg (
    .clk (clk),
    .rst (rst),
    .d   (st_d),
    .q   (st_q)
  );

  mm_out_sel #(.MEALY_MODE(MEALY_MODE)) u_out (
    .tbl_z    (tbl_z),
    .stored_z (st_q[0]),
    .z        (z)
  );
endmodule

// File: rtl/mm_top_chk.sv
module mm_top_chk #(
  parameter bit MEALY_MODE = 1'b0
) (
  input logic clk,
  input logic rst,
  input logic x1,
  input logic x2,
  input logic z,
  input logic st_b
);
  AST_RESET_TO_A: assert property (@(posedge clk)
    $past(rst) |-> (st_b == 1'b0)) else $error("reset state"); // R1
  AST_RESET_Z_LOW: assert property (@(posedge clk)
    ($past(rst) && !MEALY_MODE) |-> (z == 1'b0)) else $error("reset z"); // R1
  AST_A_TO_B: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!st_b && x1 && x2)) |-> st_b) else $error("A->B"); // R2
  AST_A_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!st_b && !(x1 && x2))) |-> !st_b) else $error("A hold"); // R2
  AST_B_TO_A: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(st_b && !x1 && !x2)) |-> !st_b) else $error("B->A"); // R3
  AST_B_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(st_b && (x1 || x2))) |-> st_b) else $error("B hold"); // R3
  AST_REG_LAG: assert property (@(posedge clk) disable iff (rst)
    (!MEALY_MODE && !$past(rst)) |->
      (z == ($past(st_b) ? ($past(x1) == $past(x2)) : ($past(x1) != $past(x2)))))
    else $error("lag"); // R6
  AST_COMB_OUT: assert property (@(posedge clk) disable iff (rst)
    MEALY_MODE |-> (z == (st_b ? (x1 == x2) : (x1 != x2)))) else $error("comb z"); // R8
endmodule

bind mm_top mm_top_chk #(.MEALY_MODE(MEALY_MODE)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .x1   (x1),
  .x2   (x2),
  .z    (z),
  .st_b (st_q[1])
);

// File: tb/mm_top_bench.sv
module mm_top_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x1  = 1'b0;
  logic x2  = 1'b0;
  logic zr;
  logic zc;
  int   checks   = 0;
  int   failures = 0;
  logic mdl_b    = 1'b0;
  bit   done     = 1'b0;

  always #10 clk = ~clk;

  mm_top #(.MEALY_MODE(1'b0)) u_mm_top (
    .clk(clk), .rst(rst), .x1(x1), .x2(x2), .z(zr));
  mm_top #(.MEALY_MODE(1'b1)) u_mm_top_comb (
    .clk(clk), .rst(rst), .x1(x1), .x2(x2), .z(zc));

  function automatic logic f_out(logic b, logic a, logic c);
    return b ? (a == c) : (a != c);
  endfunction

  function automatic logic f_nxt(logic b, logic a, logic c);
    return b ? (a | c) : (a & c);
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Called just after a falling edge; leaves just after the next falling edge.
  task automatic step(logic a, logic c);
    logic exp_z;
    x1 = a; x2 = c;
    #2;
    exp_z = f_out(mdl_b, a, c);
    chk(mdl_b ? "R5/R8" : "R4/R8", zc, exp_z);
    @(posedge clk);
    mdl_b = f_nxt(mdl_b, a, c);
    @(negedge clk);
    chk("R6", zr, exp_z);
  endtask

  // Reads the present state through the combinational instance without a clock.
  task automatic probe_state(string req);
    x1 = 1'b0; x2 = 1'b0;
    #1;
    chk(req, zc, mdl_b);
  endtask

  task automatic t_reset();
    rst = 1'b1; x1 = 1'b1; x2 = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    mdl_b = 1'b0;
    chk("R1", zr, 1'b0);
    x1 = 1'b0; x2 = 1'b1;
    #2;
    chk("R1", zc, 1'b1);
    rst = 1'b0;
    x1 = 1'b0; x2 = 1'b0;
    #1;
    chk("R1", zr, 1'b0);
  endtask

  task automatic t_table_walk();
    step(1'b0, 1'b0); probe_state("R2");
    step(1'b0, 1'b1); probe_state("R2");
    step(1'b1, 1'b0); probe_state("R2");
    step(1'b1, 1'b1); probe_state("R2");
    step(1'b0, 1'b1); probe_state("R3");
    step(1'b1, 1'b1); probe_state("R3");
    step(1'b1, 1'b0); probe_state("R3");
    step(1'b0, 1'b0); probe_state("R3");
  endtask

  task automatic t_glitch();
    logic held;
    step(1'b0, 1'b1);
    held = zr;
    x1 = 1'b1; x2 = 1'b1; #1; chk("R7", zr, held);
    x1 = 1'b0; x2 = 1'b0; #1; chk("R7", zr, held);
    x1 = 1'b1; x2 = 1'b0; #1; chk("R7", zr, held);
    step(1'b0, 1'b0);
    probe_state("R7");
  endtask

  task automatic t_reset_from_b();
    step(1'b1, 1'b1);
    probe_state("R2");
    rst = 1'b1; x1 = 1'b0; x2 = 1'b1;
    @(posedge clk);
    @(negedge clk);
    mdl_b = 1'b0;
    rst = 1'b0;
    chk("R1", zr, 1'b0);
    probe_state("R1");
  endtask

  task automatic t_random();
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[5]);
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_table_walk();
    t_glitch();
    t_reset_from_b();
    t_random();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule